// File: doc/BRIEF.md
# Per-Request Page Checkpoint Rollback Tracker

This block keeps a small fully associative table of page checkpoint records beside an address translation buffer. A network server handles one request per epoch. A global epoch counter advances each time a request begins. Every record holds a page tag, the epoch it last joined, an active and a backup physical page number, one dirty bit per cache line and a rollback flag. Checkpointing is lazy and works per line. On the first write to a line in an epoch, the block tells the data mover to save the old line into the backup page. The lines saved this way are exactly the lines the current request modified.

A failure strobe sets the rollback flag on every record that belongs to the current epoch. No data moves at that moment. After a failure, reads of marked lines are steered to the backup page. A write to a marked line first restores that line from the backup page. For each accepted access the block returns, one cycle later, the physical page to use and at most one line-copy command. The copy code is 0 for none, 1 for a save (active page to backup page) and 2 for a restore (backup page to active page).

Control is a two-state machine. ST_READY accepts an access; the transition ACCEPT, taken when `acc_valid` and `acc_ready` are both high, leads to ST_RESPOND. ST_RESPOND presents the registered response for one cycle and always returns through the transition RETURN to ST_READY. The epoch strobe and the failure strobe are handled in either state.

Top module: `ckpt_tracker`

## Requirements
- R1: After reset `epoch` is 0, `rsp_valid` is 0, `acc_ready` is 1 and the table holds no records, so the first access misses and reports `rsp_evict` = 0.
- R2: Each cycle with `req_start` high adds one to `epoch` in the next cycle, wrapping from 255 to 0. In every other cycle `epoch` holds its value.
- R3: An access is taken when `acc_valid` and `acc_ready` are both high. `acc_ready` is low in ST_RESPOND and in any cycle where `req_start` or `fail_strobe` is high. `rsp_valid` is high for exactly the one cycle after the access is taken, and `rsp_line` and `rsp_is_write` echo the access.
- R4: A tag that misses is placed in the round-robin victim slot, starting at slot 0 and moving on one slot per miss. The new record takes `new_active_ppn` and `new_backup_ppn` and joins the current epoch with every line clean. `rsp_evict` is 1 exactly when the victim slot held a record.
- R5: A write to a clean line of a record without the rollback flag returns copy code 1 (save) and the active page, and marks the line dirty.
- R6: A further write to that line in the same epoch returns copy code 0.
- R7: A write to a record from an older epoch first moves the record into the current epoch. The move clears all its dirty bits and its rollback flag, so a line that was dirty before is saved again (code 1), and reads of lines dirtied in the earlier epoch return the active page.
- R8: A failure strobe sets the rollback flag on every record whose epoch equals the current epoch. The strobe produces no response.
- R9: A read returns copy code 0. It returns the backup page exactly when the record has the rollback flag and the line is dirty; otherwise it returns the active page.
- R10: A write to a dirty line of a record with the rollback flag returns copy code 2 (restore) and the active page, and clears that line's dirty bit. After that, a read of the line returns the active page and a further write returns code 0.
- R11: A write to a clean line of a record with the rollback flag returns copy code 0 and the active page, and the line stays clean.
- R12: A failure leaves records from an older epoch untouched, so a read of one of their dirty lines still returns the active page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | A new request begins; advances the epoch |
| fail_strobe | input | 1 | The monitor found a fault in the current request |
| acc_valid | input | 1 | Memory access present |
| acc_ready | output | 1 | The block can take an access this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_tag | input | 20 | Virtual page tag of the access |
| acc_line | input | 6 | Line index within the page |
| new_active_ppn | input | 20 | Active page number for a record allocated on a miss |
| new_backup_ppn | input | 20 | Backup page number for a record allocated on a miss |
| rsp_valid | output | 1 | Response present |
| rsp_is_write | output | 1 | Echo of the access direction |
| rsp_line | output | 6 | Echo of the line index, used by the copy command |
| rsp_ppn | output | 20 | Physical page that serves the access |
| rsp_from_backup | output | 1 | 1 when `rsp_ppn` is the backup page |
| rsp_copy | output | 2 | Line copy: 0 none, 1 save, 2 restore |
| rsp_evict | output | 1 | The allocation overwrote a live record |
| epoch | output | 8 | Current global epoch |

## Verification
The properties assume that the bench holds each access request for a single cycle and gives the page numbers for a miss together with the access. They also assume that the two strobes may arrive in any state, since `acc_ready` keeps them apart from accepted accesses. The stimulus drives inputs on the falling edge and keeps `acc_valid` high for one cycle only. It waits out each response before the next access and issues strobes only between accesses, so every response can be paired with the access that caused it.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    localparam int TAG_W  = 20;
    localparam int PPN_W  = 20;
    localparam int TS_W   = 8;
    localparam int LINES  = 64;
    localparam int LINE_W = $clog2(LINES);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [TS_W-1:0]   ts;
        logic [PPN_W-1:0]  act;
        logic [PPN_W-1:0]  bak;
        logic [LINES-1:0]  dirty;
        logic              rbv;
    } ckpt_rec_t;

    typedef enum logic [1:0] {
        CP_NONE    = 2'd0,
        CP_SAVE    = 2'd1,
        CP_RESTORE = 2'd2
    } copy_e;

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_RESPOND = 1'b1
    } fsm_e;
endpackage

// File: rtl/ckpt_match.sv
module ckpt_match
    import ckpt_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [TAG_W-1:0]   ent_tag [ENTRIES],
    input  logic [TAG_W-1:0]   look_tag,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = ent_valid[g] && (ent_tag[g] == look_tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ckpt_route.sv
module ckpt_route
    import ckpt_pkg::*;
(
    input  ckpt_rec_t         rec_in,
    input  logic [LINE_W-1:0] line,
    input  logic              write,
    input  logic [TS_W-1:0]   cur_epoch,
    output ckpt_rec_t         rec_out,
    output logic              from_backup,
    output logic [PPN_W-1:0]  ppn,
    output copy_e             copy
);
    always_comb begin
        rec_out     = rec_in;
        copy        = CP_NONE;
        from_backup = 1'b0;
        if (write) begin
            // move into the current epoch before recording the write
            if (rec_out.ts != cur_epoch) begin
                rec_out.ts    = cur_epoch;
                rec_out.dirty = '0;
                rec_out.rbv   = 1'b0;
            end
            if (rec_out.rbv) begin
                if (rec_out.dirty[line]) begin
                    copy                = CP_RESTORE;
                    rec_out.dirty[line] = 1'b0;
                end
            end else if (!rec_out.dirty[line]) begin
                copy                = CP_SAVE;
                rec_out.dirty[line] = 1'b1;
            end
        end else begin
            from_backup = rec_in.rbv && rec_in.dirty[line];
        end
        ppn = from_backup ? rec_in.bak : rec_out.act;
    end
endmodule

// File: rtl/ckpt_tracker.sv
module ckpt_tracker
    import ckpt_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              fail_strobe,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic              acc_write,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [PPN_W-1:0]  new_active_ppn,
    input  logic [PPN_W-1:0]  new_backup_ppn,
    output logic              rsp_valid,
    output logic              rsp_is_write,
    output logic [LINE_W-1:0] rsp_line,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_from_backup,
    output logic [1:0]        rsp_copy,
    output logic              rsp_evict,
    output logic [TS_W-1:0]   epoch
);
    ckpt_rec_t          table_q [ENTRIES];
    logic [ENTRIES-1:0] ent_valid;
    logic [TAG_W-1:0]   ent_tag [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    fsm_e               state_q, state_d;

    logic               hit;
    logic [IDX_W-1:0]   hit_idx, slot;
    ckpt_rec_t          cur_rec, upd_rec;
    logic               r_backup;
    logic [PPN_W-1:0]   r_ppn;
    copy_e              r_copy;
    logic               accept;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign ent_valid[g] = table_q[g].valid;
        assign ent_tag[g]   = table_q[g].tag;
    end

    ckpt_match #(.ENTRIES(ENTRIES)) u_match (
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .look_tag  (acc_tag),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    assign slot = hit ? hit_idx : rr_q;

    always_comb begin
        if (hit) begin
            cur_rec = table_q[hit_idx];
        end else begin
            cur_rec.valid = 1'b1;
            cur_rec.tag   = acc_tag;
            cur_rec.ts    = epoch;
            cur_rec.act   = new_active_ppn;
            cur_rec.bak   = new_backup_ppn;
            cur_rec.dirty = '0;
            cur_rec.rbv   = 1'b0;
        end
    end

    ckpt_route u_route (
        .rec_in      (cur_rec),
        .line        (acc_line),
        .write       (acc_write),
        .cur_epoch   (epoch),
        .rec_out     (upd_rec),
        .from_backup (r_backup),
        .ppn         (r_ppn),
        .copy        (r_copy)
    );

    assign acc_ready = (state_q == ST_READY) && !req_start && !fail_strobe;
    assign accept    = acc_valid && acc_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (accept) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_READY;
        endcase
    end

    // record table, victim pointer and epoch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
            rr_q  <= '0;
            epoch <= '0;
        end else begin
            if (req_start) epoch <= epoch + 1'b1;
            if (fail_strobe) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (table_q[i].valid && table_q[i].ts == epoch)
                        table_q[i].rbv <= 1'b1;
                end
            end else if (accept) begin
                table_q[slot] <= upd_rec;
                if (!hit) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_is_write    <= 1'b0;
            rsp_line        <= '0;
            rsp_ppn         <= '0;
            rsp_from_backup <= 1'b0;
            rsp_copy        <= 2'd0;
            rsp_evict       <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_is_write    <= acc_write;
                rsp_line        <= acc_line;
                rsp_ppn         <= r_ppn;
                rsp_from_backup <= r_backup;
                rsp_copy        <= r_copy;
                rsp_evict       <= !hit && table_q[rr_q].valid;
            end
        end
    end
endmodule

// File: rtl/ckpt_tracker_chk.sv
module ckpt_tracker_chk
    import ckpt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_start,
    input logic            fail_strobe,
    input logic            acc_valid,
    input logic            acc_ready,
    input logic            rsp_valid,
    input logic            rsp_is_write,
    input logic            rsp_from_backup,
    input logic [1:0]      rsp_copy,
    input logic [TS_W-1:0] epoch
);
    p_ready_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start || fail_strobe) |-> !acc_ready);

    p_resp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> rsp_valid);

    p_resp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_epoch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |=> (epoch == TS_W'($past(epoch) + 1'b1)));

    p_epoch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_start |=> $stable(epoch));

    p_fail_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_strobe |=> !rsp_valid);

    p_read_nocopy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_write) |-> (rsp_copy == 2'd0));

    p_backup_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_from_backup) |-> !rsp_is_write);

    p_copy_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_copy != 2'd3));
endmodule

bind ckpt_tracker ckpt_tracker_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_start       (req_start),
    .fail_strobe     (fail_strobe),
    .acc_valid       (acc_valid),
    .acc_ready       (acc_ready),
    .rsp_valid       (rsp_valid),
    .rsp_is_write    (rsp_is_write),
    .rsp_from_backup (rsp_from_backup),
    .rsp_copy        (rsp_copy),
    .epoch           (epoch)
);

// File: tb/ckpt_tracker_tb_top.sv
module ckpt_tracker_tb_top;
    import ckpt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ENT        = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_start = 1'b0;
    logic              fail_strobe = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_ready;
    logic              acc_write = 1'b0;
    logic [TAG_W-1:0]  acc_tag = '0;
    logic [LINE_W-1:0] acc_line = '0;
    logic [PPN_W-1:0]  new_active_ppn = '0;
    logic [PPN_W-1:0]  new_backup_ppn = '0;
    logic              rsp_valid;
    logic              rsp_is_write;
    logic [LINE_W-1:0] rsp_line;
    logic [PPN_W-1:0]  rsp_ppn;
    logic              rsp_from_backup;
    logic [1:0]        rsp_copy;
    logic              rsp_evict;
    logic [TS_W-1:0]   epoch;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ckpt_tracker #(.ENTRIES(ENT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .fail_strobe(fail_strobe),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
        .acc_tag(acc_tag), .acc_line(acc_line), .new_active_ppn(new_active_ppn),
        .new_backup_ppn(new_backup_ppn), .rsp_valid(rsp_valid), .rsp_is_write(rsp_is_write),
        .rsp_line(rsp_line), .rsp_ppn(rsp_ppn), .rsp_from_backup(rsp_from_backup),
        .rsp_copy(rsp_copy), .rsp_evict(rsp_evict), .epoch(epoch)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [PPN_W-1:0]  ppn;
        logic              fb;
        logic [1:0]        copy;
        logic              evict;
        logic [LINE_W-1:0] line;
        logic              wr;
        string             req;
    } exp_t;
    exp_t exp_q [$];

    // reference model, built from the requirements
    logic              m_valid [ENT];
    logic [TAG_W-1:0]  m_tag   [ENT];
    logic [TS_W-1:0]   m_ts    [ENT];
    logic [PPN_W-1:0]  m_act   [ENT];
    logic [PPN_W-1:0]  m_bak   [ENT];
    logic [LINES-1:0]  m_dirty [ENT];
    logic              m_rbv   [ENT];
    int                m_rr = 0;
    logic [TS_W-1:0]   m_gt = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_access(input logic [TAG_W-1:0] tag, input int line, input bit wr,
                             input logic [PPN_W-1:0] act, input logic [PPN_W-1:0] bak,
                             input string req);
        exp_t e;
        int   idx = 0;
        bit   hit = 1'b0;
        @(negedge clk);
        acc_valid = 1'b1; acc_tag = tag; acc_line = LINE_W'(line); acc_write = wr;
        new_active_ppn = act; new_backup_ppn = bak;
        for (int i = 0; i < ENT; i++)
            if (!hit && m_valid[i] && m_tag[i] == tag) begin hit = 1'b1; idx = i; end
        e.evict = 1'b0;
        if (!hit) begin
            idx = m_rr;
            e.evict = m_valid[idx];
            m_valid[idx] = 1'b1; m_tag[idx] = tag; m_ts[idx] = m_gt;
            m_act[idx] = act; m_bak[idx] = bak; m_dirty[idx] = '0; m_rbv[idx] = 1'b0;
            m_rr = (m_rr + 1) % ENT;
        end
        e.copy = 2'd0; e.fb = 1'b0;
        if (wr) begin
            if (m_ts[idx] != m_gt) begin
                m_ts[idx] = m_gt; m_dirty[idx] = '0; m_rbv[idx] = 1'b0;
            end
            if (m_rbv[idx]) begin
                if (m_dirty[idx][line]) begin e.copy = 2'd2; m_dirty[idx][line] = 1'b0; end
            end else if (!m_dirty[idx][line]) begin
                e.copy = 2'd1; m_dirty[idx][line] = 1'b1;
            end
        end else begin
            e.fb = m_rbv[idx] && m_dirty[idx][line];
        end
        e.ppn = e.fb ? m_bak[idx] : m_act[idx];
        e.line = LINE_W'(line); e.wr = wr; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        check(acc_ready == 1'b0, "R3", "ready low while responding", acc_ready, 0);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_start(input string req);
        @(negedge clk);
        req_start = 1'b1;
        #1 check(acc_ready == 1'b0, "R3", "ready low on epoch strobe", acc_ready, 0);
        m_gt = m_gt + 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(epoch == m_gt, req, "epoch", epoch, m_gt);
    endtask

    task automatic pulse_fail();
        @(negedge clk);
        fail_strobe = 1'b1;
        #1 check(acc_ready == 1'b0, "R3", "ready low on failure strobe", acc_ready, 0);
        for (int i = 0; i < ENT; i++)
            if (m_valid[i] && m_ts[i] == m_gt) m_rbv[i] = 1'b1;
        @(negedge clk);
        fail_strobe = 1'b0;
        check(rsp_valid == 1'b0, "R8", "no response on failure", rsp_valid, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_ppn == e.ppn, e.req, "ppn", rsp_ppn, e.ppn);
                check(rsp_from_backup == e.fb, e.req, "from_backup", rsp_from_backup, e.fb);
                check(rsp_copy == e.copy, e.req, "copy", rsp_copy, e.copy);
                check(rsp_evict == e.evict, e.req, "evict", rsp_evict, e.evict);
                check(rsp_line == e.line && rsp_is_write == e.wr, "R3", "echo",
                      {rsp_is_write, rsp_line}, {e.wr, e.line});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [TAG_W-1:0] TAG_A = 20'h0A11A;
    localparam logic [TAG_W-1:0] TAG_B = 20'h0B22B;

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_ts[i] = '0; m_act[i] = '0;
            m_bak[i] = '0; m_dirty[i] = '0; m_rbv[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(epoch == 0, "R1", "epoch after reset", epoch, 0);
        check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(acc_ready == 1, "R1", "ready after reset", acc_ready, 1);

        for (int i = 0; i < 5; i++) pulse_start("R2");

        // epoch 5: save lines 7 and 2 (R1 empty table, R4 alloc, R5 save)
        do_access(TAG_A, 7, 1'b1, 20'h10007, 20'h20007, "R5");
        do_access(TAG_A, 2, 1'b1, 20'h0, 20'h0, "R5");
        do_access(TAG_A, 7, 1'b1, 20'h0, 20'h0, "R6");
        do_access(TAG_A, 3, 1'b0, 20'h0, 20'h0, "R9");
        pulse_fail();
        do_access(TAG_A, 7, 1'b0, 20'h0, 20'h0, "R9");
        do_access(TAG_A, 3, 1'b0, 20'h0, 20'h0, "R9");
        do_access(TAG_A, 1, 1'b1, 20'h0, 20'h0, "R11");
        do_access(TAG_A, 1, 1'b0, 20'h0, 20'h0, "R11");
        do_access(TAG_A, 2, 1'b1, 20'h0, 20'h0, "R10");
        do_access(TAG_A, 2, 1'b0, 20'h0, 20'h0, "R10");
        do_access(TAG_A, 2, 1'b1, 20'h0, 20'h0, "R10");

        // epoch 6: lazy move of the record
        pulse_start("R2");
        do_access(TAG_A, 4, 1'b1, 20'h0, 20'h0, "R7");
        do_access(TAG_A, 7, 1'b0, 20'h0, 20'h0, "R7");
        do_access(TAG_A, 4, 1'b1, 20'h0, 20'h0, "R6");
        do_access(TAG_B, 0, 1'b1, 20'h1B000, 20'h2B000, "R4");

        // epoch 7: failure must leave older records alone
        pulse_start("R2");
        pulse_fail();
        do_access(TAG_B, 0, 1'b0, 20'h0, 20'h0, "R12");
        do_access(TAG_A, 4, 1'b0, 20'h0, 20'h0, "R12");
        do_access(TAG_B, 0, 1'b1, 20'h0, 20'h0, "R7");

        // fill the table and wrap the round-robin pointer
        for (int i = 0; i < 6; i++)
            do_access(TAG_W'(20'h30000 + i), i, 1'b1,
                      PPN_W'(20'h40000 + i), PPN_W'(20'h50000 + i), "R4");
        do_access(20'h3FFFF, 9, 1'b0, 20'h4FFFF, 20'h5FFFF, "R4");
        do_access(TAG_A, 4, 1'b0, 20'h1A0A0, 20'h2A0A0, "R4");

        // epoch wrap
        while (epoch != 8'd255) pulse_start("R2");
        pulse_start("R2");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3", "missing responses", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule